// File: doc/BRIEF.md
# SECDED Hamming Memory Codec

This block guards narrow memory words with a single-error-correcting, double-error-detecting Hamming code. The write path turns a data byte into a 13-bit stored word. In that word the check bits sit at the power-of-two positions, the data bits fill the remaining positions in ascending order, and an overall parity bit sits at position 0. The read path takes a word retrieved from the array and recomputes the check bits from the data positions. It compares them with the stored ones to form a syndrome. It then returns the data byte, corrected where the code allows, with exactly one of three verdict flags: clean, fixed or fatal.

The encoder is purely combinational. The decoder is combinational too, followed by one optional register stage chosen by a parameter and enabled by default. The data width is a parameter. The check-bit count, the code width and the bit layout are all derived from it, and the 8-bit layout is the default. The overall parity polarity is a parameter, with even parity as the default. The surrounding memory array and any scrub or retry policy are the caller's concern.

Top module: `secded_codec`

## Requirements
- R1: Code positions are numbered 1 to 12, and position p is bit p of the code word. Check bits occupy positions 1, 2, 4 and 8. The data MSB through the data LSB fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. The check bit at position 2^i is the XOR of every data position whose index has bit i set. Data 8'b10011100 encodes to 13'h069F.
- R2: Bit 0 of the code word is an overall parity bit. It makes the XOR of all 13 bits equal 0 when ODD_PAR=0 (the default), and equal 1 when ODD_PAR=1.
- R3: rd_syndrome holds the recomputed check bits XORed with the stored ones. Bit 3 is the position-8 check and bit 0 is the position-1 check. When a single position p in 1..12 is inverted, the syndrome equals p.
- R4: A zero syndrome with correct overall parity raises rd_clean, and the data bits are returned unchanged.
- R5: A nonzero syndrome that is not a power of two and is at most 12, together with failing overall parity, inverts the data bit at that position and raises rd_fixed.
- R6: A syndrome with exactly one bit set, together with failing overall parity, raises rd_fixed and returns the data positions unchanged.
- R7: A zero syndrome with failing overall parity (only position 0 flipped) raises rd_fixed and returns the data unchanged.
- R8: A nonzero syndrome with correct overall parity raises rd_fatal, and the data positions are returned uncorrected.
- R9: A syndrome of 13, 14 or 15 with failing overall parity raises rd_fatal, and the data positions are returned uncorrected.
- R10: Exactly one of rd_clean, rd_fixed and rd_fatal is high in every cycle, and the flags belong to the same read as rd_data and rd_syndrome.
- R11: With OUT_REG=1 (the default), the read outputs appear one clock after rd_code is presented. During reset they read data 0, syndrome 0 and rd_clean=1. With OUT_REG=0, the read outputs follow rd_code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional read register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Data byte to encode |
| wr_code | output | 13 | Encoded word for storage; bit p is code position p |
| rd_code | input | 13 | Word retrieved from memory |
| rd_data | output | 8 | Decoded, possibly corrected, data byte |
| rd_syndrome | output | 4 | Syndrome; bit 3 is the position-8 check |
| rd_clean | output | 1 | No error found |
| rd_fixed | output | 1 | Single error corrected |
| rd_fatal | output | 1 | Uncorrectable error; data not modified |

## Verification
A wrong mask in a check-bit equation shows immediately on wr_code for any byte that drives that check. On the read side it produces a syndrome that points at the wrong position, so a single injected flip returns corrupted data and the wrong flag on the very next registered read. A mistake in the classifier between the parity result and the syndrome range shows up as a wrong verdict flag. Such a mistake also shows up as an inverted bit on patterns with two or three flips, including the syndromes that point outside the word. A broken output stage shifts every read result by a cycle, or breaks the reset values.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [1:0] {
      VERDICT_CLEAN = 2'd0,
      VERDICT_FIXED = 2'd1,
      VERDICT_FATAL = 2'd2
   } verdict_e;

   // smallest k with 2^k >= data + k + 1
   function automatic int chk_bits(input int dw);
      int k;
      k = 1;
      for (int t = 1; t < 8; t++)
         if ((1 << k) < dw + k + 1) k = k + 1;
      return k;
   endfunction

   function automatic bit is_pow2(input int p);
      return (p != 0) && ((p & (p - 1)) == 0);
   endfunction

   // position of the j-th data bit counted from the data MSB
   function automatic int data_pos(input int j);
      int cnt;
      int pos;
      cnt = 0;
      pos = 0;
      for (int p = 1; p < 64; p++) begin
         if (!is_pow2(p)) begin
            if (cnt == j && pos == 0) pos = p;
            cnt = cnt + 1;
         end
      end
      return pos;
   endfunction

   // positions 1..n whose index carries bit i
   function automatic logic [63:0] cover_mask(input int n, input int i);
      logic [63:0] m;
      m = '0;
      for (int p = 1; p < 64; p++)
         if (p <= n && ((p >> i) & 1) == 1) m[p] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
   import secded_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit ODD_PAR = 1'b0
)(
   input  logic [DATA_W-1:0]                    data_i,
   output logic [DATA_W+chk_bits(DATA_W):0]     code_o
);
   localparam int CHK_W  = chk_bits(DATA_W);
   localparam int N      = DATA_W + CHK_W;
   localparam int CODE_W = N + 1;

   logic [CODE_W-1:0] w;

   always_comb begin
      w = '0;
      for (int j = 0; j < DATA_W; j++)
         w[data_pos(j)] = data_i[DATA_W-1-j];
      for (int i = 0; i < CHK_W; i++)
         w[1 << i] = ^(w & CODE_W'(cover_mask(N, i)));
      w[0] = (^w) ^ ODD_PAR;
   end

   assign code_o = w;
endmodule

// File: rtl/secded_syn.sv
module secded_syn
   import secded_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit ODD_PAR = 1'b0
)(
   input  logic [DATA_W+chk_bits(DATA_W):0]     code_i,
   output logic [chk_bits(DATA_W)-1:0]          syn_o,
   output logic                                 perr_o
);
   localparam int CHK_W  = chk_bits(DATA_W);
   localparam int N      = DATA_W + CHK_W;
   localparam int CODE_W = N + 1;

   for (genvar i = 0; i < CHK_W; i++) begin : g_syn
      localparam logic [63:0] MASK = cover_mask(N, i);
      assign syn_o[i] = ^(code_i & MASK[CODE_W-1:0]);
   end

   assign perr_o = (^code_i) ^ ODD_PAR;
endmodule

// File: rtl/secded_fix.sv
module secded_fix
   import secded_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic [DATA_W+chk_bits(DATA_W):0]     code_i,
   input  logic [chk_bits(DATA_W)-1:0]          syn_i,
   input  logic                                 perr_i,
   output logic [DATA_W-1:0]                    raw_o,
   output logic [DATA_W-1:0]                    data_o,
   output verdict_e                             verdict_o
);
   localparam int CHK_W = chk_bits(DATA_W);
   localparam int N     = DATA_W + CHK_W;

   logic syn_zero;
   logic in_range;
   logic fix_en;

   assign syn_zero = (syn_i == '0);
   assign in_range = (int'(syn_i) <= N);
   assign fix_en   = perr_i && !syn_zero && in_range;

   for (genvar j = 0; j < DATA_W; j++) begin : g_bit
      localparam int P = data_pos(j);
      assign raw_o[DATA_W-1-j]  = code_i[P];
      assign data_o[DATA_W-1-j] = code_i[P] ^ (fix_en && (int'(syn_i) == P));
   end

   always_comb begin
      if (syn_zero)
         verdict_o = perr_i ? VERDICT_FIXED : VERDICT_CLEAN;
      else if (fix_en)
         verdict_o = VERDICT_FIXED;
      else
         verdict_o = VERDICT_FATAL;
   end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
   import secded_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit ODD_PAR = 1'b0,
   parameter bit OUT_REG = 1'b1
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [DATA_W-1:0]                    wr_data,
   output logic [DATA_W+chk_bits(DATA_W):0]     wr_code,
   input  logic [DATA_W+chk_bits(DATA_W):0]     rd_code,
   output logic [DATA_W-1:0]                    rd_data,
   output logic [chk_bits(DATA_W)-1:0]          rd_syndrome,
   output logic                                 rd_clean,
   output logic                                 rd_fixed,
   output logic                                 rd_fatal
);
   localparam int CHK_W = chk_bits(DATA_W);

   if (DATA_W < 1 || DATA_W > 57) begin : g_bad_width
      $error("secded_codec: DATA_W must lie in 1..57");
   end

   logic [CHK_W-1:0]  c_syn;
   logic              c_perr;
   logic [DATA_W-1:0] c_raw;
   logic [DATA_W-1:0] c_data;
   verdict_e          c_verdict;
   verdict_e          q_verdict;

   secded_enc #(.DATA_W(DATA_W), .ODD_PAR(ODD_PAR)) u_enc (
      .data_i (wr_data),
      .code_o (wr_code)
   );

   secded_syn #(.DATA_W(DATA_W), .ODD_PAR(ODD_PAR)) u_syn (
      .code_i (rd_code),
      .syn_o  (c_syn),
      .perr_o (c_perr)
   );

   secded_fix #(.DATA_W(DATA_W)) u_fix (
      .code_i    (rd_code),
      .syn_i     (c_syn),
      .perr_i    (c_perr),
      .raw_o     (c_raw),
      .data_o    (c_data),
      .verdict_o (c_verdict)
   );

   if (OUT_REG) begin : g_reg
      logic armed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data     <= '0;
            rd_syndrome <= '0;
            q_verdict   <= VERDICT_CLEAN;
            armed       <= 1'b0;
         end else begin
            rd_data     <= c_data;
            rd_syndrome <= c_syn;
            q_verdict   <= c_verdict;
            armed       <= 1'b1;
         end
      end

      // R11
      out_stage_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> (rd_data == $past(c_data) && rd_syndrome == $past(c_syn)));
   end else begin : g_comb
      assign rd_data     = c_data;
      assign rd_syndrome = c_syn;
      assign q_verdict   = c_verdict;
   end

   assign rd_clean = (q_verdict == VERDICT_CLEAN);
   assign rd_fixed = (q_verdict == VERDICT_FIXED);
   assign rd_fatal = (q_verdict == VERDICT_FATAL);

   // R10
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rd_clean, rd_fixed, rd_fatal}) == 1);

   // R4
   clean_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_verdict == VERDICT_CLEAN) |-> (c_syn == '0 && !c_perr && c_data == c_raw));

   // R8
   fatal_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_verdict == VERDICT_FATAL) |-> (c_data == c_raw));

   // R7
   parity_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_syn == '0 && c_perr) |-> (c_verdict == VERDICT_FIXED && c_data == c_raw));

   // R5
   single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_verdict == VERDICT_FIXED) |-> ($countones(c_data ^ c_raw) <= 1));
endmodule

// File: tb/secded_codec_tb.sv
module secded_codec_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  wr_data;
   logic [12:0] rd_code;
   logic [12:0] wr_code_e, wr_code_o;
   logic [7:0]  rd_data_e, rd_data_o;
   logic [3:0]  syn_e, syn_o;
   logic        cl_e, fx_e, ft_e, cl_o, fx_o, ft_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   secded_codec u_dut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code_e),
      .rd_code(rd_code), .rd_data(rd_data_e), .rd_syndrome(syn_e),
      .rd_clean(cl_e), .rd_fixed(fx_e), .rd_fatal(ft_e));

   secded_codec #(.ODD_PAR(1'b1), .OUT_REG(1'b0)) u_dut_odd (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code_o),
      .rd_code(rd_code), .rd_data(rd_data_o), .rd_syndrome(syn_o),
      .rd_clean(cl_o), .rd_fixed(fx_o), .rd_fatal(ft_o));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [12:0] ref_enc(input logic [7:0] d, input bit odd);
      logic [12:0] c;
      c = '0;
      c[3] = d[7]; c[5] = d[6]; c[6] = d[5]; c[7] = d[4];
      c[9] = d[3]; c[10] = d[2]; c[11] = d[1]; c[12] = d[0];
      c[1] = c[3] ^ c[5] ^ c[7] ^ c[9] ^ c[11];
      c[2] = c[3] ^ c[6] ^ c[7] ^ c[10] ^ c[11];
      c[4] = c[5] ^ c[6] ^ c[7] ^ c[12];
      c[8] = c[9] ^ c[10] ^ c[11] ^ c[12];
      c[0] = (^c[12:1]) ^ odd;
      return c;
   endfunction

   function automatic logic [7:0] pull(input logic [12:0] c);
      return {c[3], c[5], c[6], c[7], c[9], c[10], c[11], c[12]};
   endfunction

   // returns {data[7:0], syn[3:0], clean, fixed, fatal}
   function automatic logic [14:0] ref_dec(input logic [12:0] c, input bit odd);
      logic [3:0] s;
      logic       perr;
      s[0] = c[1] ^ c[3] ^ c[5] ^ c[7] ^ c[9] ^ c[11];
      s[1] = c[2] ^ c[3] ^ c[6] ^ c[7] ^ c[10] ^ c[11];
      s[2] = c[4] ^ c[5] ^ c[6] ^ c[7] ^ c[12];
      s[3] = c[8] ^ c[9] ^ c[10] ^ c[11] ^ c[12];
      perr = (^c) ^ odd;
      if (s == 4'd0)
         return {pull(c), s, !perr, perr, 1'b0};
      else if (perr && s <= 4'd12)
         return {pull(c ^ (13'd1 << s)), s, 3'b010};
      else
         return {pull(c), s, 3'b001};
   endfunction

   function automatic string tag_of(input logic [14:0] r, input logic [12:0] c, input bit odd);
      logic [3:0] s;
      s = r[6:3];
      if (r[2]) return "R4";
      if (r[0]) return (((^c) ^ odd) && s > 4'd12) ? "R9" : "R8";
      if (s == 4'd0) return "R7";
      if ((s & (s - 4'd1)) == 4'd0) return "R6";
      return "R5";
   endfunction

   task automatic apply(input logic [7:0] d, input logic [12:0] c);
      logic [14:0] eo, ee;
      @(negedge clk);
      wr_data = d;
      rd_code = c;
      #1;
      chk(wr_code_e == ref_enc(d, 1'b0), "R1 R2 encode even", 32'(wr_code_e), 32'(ref_enc(d, 1'b0)));
      chk(wr_code_o == ref_enc(d, 1'b1), "R2 encode odd", 32'(wr_code_o), 32'(ref_enc(d, 1'b1)));
      eo = ref_dec(c, 1'b1);
      chk({rd_data_o, syn_o, cl_o, fx_o, ft_o} == eo,
          {"R3 R11 same-cycle ", tag_of(eo, c, 1'b1)},
          32'({rd_data_o, syn_o, cl_o, fx_o, ft_o}), 32'(eo));
      chk($countones({cl_o, fx_o, ft_o}) == 1, "R10 one flag", 32'({cl_o, fx_o, ft_o}), 32'd0);
      ee = ref_dec(c, 1'b0);
      @(posedge clk);
      #1;
      chk({rd_data_e, syn_e, cl_e, fx_e, ft_e} == ee,
          {"R3 R11 registered ", tag_of(ee, c, 1'b0)},
          32'({rd_data_e, syn_e, cl_e, fx_e, ft_e}), 32'(ee));
   endtask

   function automatic logic [12:0] bitpos(input int p);
      return 13'd1 << p;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [12:0] base;
      rst_n   = 1'b0;
      wr_data = '0;
      rd_code = 13'h1FFF;
      repeat (3) @(posedge clk);
      #1;
      chk({rd_data_e, syn_e, cl_e, fx_e, ft_e} == 15'b00000000_0000_100,
          "R11 reset state", 32'({rd_data_e, syn_e, cl_e, fx_e, ft_e}), 32'h4);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 worked example
      base = ref_enc(8'b10011100, 1'b0);
      apply(8'b10011100, base);
      chk(wr_code_e == 13'h069F, "R1 example code", 32'(wr_code_e), 32'h069F);
      // R3 R5 position 6 flipped
      apply(8'h00, base ^ bitpos(6));
      chk(syn_e == 4'b0110 && rd_data_e == 8'b10011100 && fx_e, "R3 R5 example repair",
          32'({rd_data_e, syn_e}), 32'({8'b10011100, 4'b0110}));
      // R6 check-bit hit at position 8
      apply(8'h00, base ^ bitpos(8));
      chk(rd_data_e == 8'b10011100 && fx_e && syn_e == 4'd8, "R6 check bit hit",
          32'({rd_data_e, syn_e}), 32'({8'b10011100, 4'd8}));
      // R7 only parity bit flipped
      apply(8'h00, base ^ bitpos(0));
      chk(rd_data_e == 8'b10011100 && fx_e && syn_e == 4'd0, "R7 parity bit only",
          32'({rd_data_e, syn_e}), 32'({8'b10011100, 4'd0}));
      // R8 double error
      apply(8'h00, base ^ bitpos(3) ^ bitpos(6));
      chk(ft_e && rd_data_e == pull(base ^ bitpos(3) ^ bitpos(6)), "R8 double error",
          32'({rd_data_e, ft_e}), 32'({pull(base ^ bitpos(3) ^ bitpos(6)), 1'b1}));
      // R9 syndrome 13 and 15 with failing parity
      apply(8'h00, base ^ bitpos(1) ^ bitpos(4) ^ bitpos(8));
      chk(ft_e && syn_e == 4'd13, "R9 syndrome 13", 32'({syn_e, ft_e}), 32'({4'd13, 1'b1}));
      apply(8'h00, base ^ bitpos(3) ^ bitpos(4) ^ bitpos(8));
      chk(ft_e && syn_e == 4'd15 && rd_data_e == pull(base ^ bitpos(3)),
          "R9 syndrome 15", 32'({rd_data_e, syn_e, ft_e}), 32'({pull(base ^ bitpos(3)), 4'd15, 1'b1}));
      // R4 clean words at extremes
      apply(8'h00, ref_enc(8'h00, 1'b0));
      apply(8'hFF, ref_enc(8'hFF, 1'b0));

      void'($urandom(32'h5EC0DE));
      for (int v = 0; v < 600; v++) begin
         logic [7:0]  d;
         logic [12:0] c;
         int          kind, a, b, e;
         d    = 8'($urandom);
         c    = ref_enc(d, 1'b0);
         kind = int'($urandom % 5);
         a    = int'($urandom % 13);
         b    = (a + 1 + int'($urandom % 12)) % 13;
         e    = (b + 1 + int'($urandom % 11)) % 13;
         if (e == a) e = (e + 1) % 13;
         if (e == b) e = (e + 1) % 13;
         if (e == a) e = (e + 1) % 13;
         case (kind)
            1: c = c ^ bitpos(a);
            2: c = c ^ bitpos(a) ^ bitpos(b);
            3: c = 13'($urandom);
            4: c = c ^ bitpos(a) ^ bitpos(b) ^ bitpos(e);
            default: ;
         endcase
         apply(d, c);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule